// File: doc/BRIEF.md
# SPI Save Memory Responder

This block answers as the save chip of a cartridge. It sits on a byte-level serial link: the shift register that turns SCK edges into bytes lives outside it. Every byte that arrives with the strobe, while chip-select is low, produces exactly one response byte one clock later. The first byte of each select period is an opcode. Read and write opcodes are followed by address bytes, most significant first, and then by a stream of data bytes. The address steps by one after each data byte.

An input picks one of two command personalities: serial EEPROM or serial flash. They differ in how they treat addresses past the end of the store. The store size is a parameter, and it fixes the number of address bytes. Stores of 512 bytes or less take one address byte. The EEPROM personality then takes address bit 8 from opcode bit 3. Stores above 64 KiB take three address bytes, and all other sizes take two. A status register carries a write-enable latch in bit 1. Writes to the store happen only while that latch is set.

Top module: `spi_save_responder`

## Requirements
- R1: While `cs_n` is high a strobed byte gets no response and changes no state. The first strobed byte after `cs_n` falls is taken as the opcode and answers 0xFF.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. After opcode 0x05, each further byte answers the status byte: 0x02 when the latch is set, 0x00 when it is clear.
- R3: Read opcodes (0x03, and 0x0B for EEPROM) and write opcodes (0x02, 0x0A) are followed by address bytes, most significant first, and each address byte answers 0xFF. There is one address byte for `MEM_BYTES` <= 512, three for `MEM_BYTES` > 65536, and two otherwise.
- R4: With one address byte and `is_flash` low, opcode bit 3 becomes address bit 8. So 0x0A and 0x0B reach the upper 256 bytes and 0x02 and 0x03 reach the lower 256.
- R5: EEPROM reads (0x03, 0x0B) use the address modulo `MEM_BYTES`, so a read that runs off the end continues at byte 0.
- R6: EEPROM writes (0x02, 0x0A) to an address at or beyond `MEM_BYTES` store nothing and answer 0xFF.
- R7: A flash read (0x03) answers the stored byte inside the store and 0xFF at or beyond `MEM_BYTES`.
- R8: Flash 0x02 stores the data byte and answers 0xFF. Flash 0x0A stores the data byte and answers the byte that was there before.
- R9: The address steps by one after every data byte, whether it is read or written.
- R10: A data byte is stored only while the write-enable latch is set. The latch clears when `cs_n` rises after a select period in which a byte was stored.
- R11: A rise of `cs_n` ends the current command, so the next byte after `cs_n` falls again is a new opcode.
- R12: Every store location reads 0xFF until it is written.
- R13: `resp_valid` is high for exactly the clock cycle after a strobe accepted with `cs_n` low, and `resp_byte` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip-select, active low |
| byte_stb | input | 1 | One-cycle strobe: a byte has arrived |
| byte_in | input | 8 | Byte received from the host |
| is_flash | input | 1 | 1 selects the flash command set, 0 selects EEPROM |
| resp_valid | output | 1 | Response byte valid, one cycle after the strobe |
| resp_byte | output | 8 | Byte returned to the host |

## Verification
Two instances are driven: a 512-byte store with one address byte and a 1 KiB store with two. This lets the address-byte count and the opcode-bit-8 preset be checked against each other. The read tests include a read through the last location of each store. That read tells EEPROM wrap-around apart from the flash 0xFF answer. The same read with opcodes 0x03 and 0x0B tells the two 256-byte halves apart. Writes are issued with the latch set and with it clear, and also just past the end of the store. A read afterwards shows which of them landed and whether page-write answered the old byte.

// File: rtl/spi_save_pkg.sv
package spi_save_pkg;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_HOLD = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    RS_FF     = 2'd0,
    RS_STATUS = 2'd1,
    RS_MEM    = 2'd2
  } rsel_t;

  localparam logic [7:0] OP_PROG     = 8'h02;
  localparam logic [7:0] OP_READ     = 8'h03;
  localparam logic [7:0] OP_WRDI     = 8'h04;
  localparam logic [7:0] OP_RDSR     = 8'h05;
  localparam logic [7:0] OP_WREN     = 8'h06;
  localparam logic [7:0] OP_WRITE_HI = 8'h0A;
  localparam logic [7:0] OP_READ_HI  = 8'h0B;
  localparam logic [7:0] IDLE_BYTE   = 8'hFF;

  function automatic int addr_bytes_for(input int mem_bytes);
    if (mem_bytes > 65536)     return 3;
    else if (mem_bytes <= 512) return 1;
    else                       return 2;
  endfunction

  function automatic logic is_rw_op(input logic [7:0] op);
    return (op == OP_PROG) || (op == OP_READ) ||
           (op == OP_WRITE_HI) || (op == OP_READ_HI);
  endfunction

endpackage

// File: rtl/save_mem_array.sv
module save_mem_array #(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] store [DEPTH];

  // erased state of a fresh save chip
  initial begin
    for (int i = 0; i < DEPTH; i++) store[i] = 8'hFF;
  end

  // read-first: a page-write sees the byte it replaces
  always_ff @(posedge clk) begin
    if (rd_en) rdata <= store[addr];
    if (we)    store[addr] <= wdata;
  end

endmodule

// File: rtl/save_cmd_seq.sv
module save_cmd_seq
  import spi_save_pkg::*;
#(
  parameter int MEM_BYTES  = 512,
  parameter int ADDR_BYTES = 1,
  parameter int MEM_AW     = 9,
  parameter int AREG_W     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              byte_stb,
  input  logic [7:0]        byte_in,
  input  logic              is_flash,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output rsel_t             rsel,
  output logic              wel
);

  localparam bit                TINY      = (ADDR_BYTES == 1);
  localparam logic [AREG_W-1:0] LIMIT     = AREG_W'(MEM_BYTES);
  localparam logic [1:0]        ACNT_INIT = 2'(ADDR_BYTES - 1);

  phase_t            phase;
  logic [7:0]        cmd;
  logic [1:0]        acnt;
  logic [AREG_W-1:0] addr;
  logic              wrote;

  logic stb_act, in_range, rd_op, wr_op;

  assign stb_act  = byte_stb & ~cs_n;
  assign in_range = (addr < LIMIT);
  assign rd_op    = (cmd == OP_READ) || (!is_flash && cmd == OP_READ_HI);
  assign wr_op    = (cmd == OP_PROG) || (cmd == OP_WRITE_HI);
  assign mem_addr = addr[MEM_AW-1:0];

  always_comb begin
    mem_we = 1'b0;
    rsel   = RS_FF;
    if (stb_act) begin
      case (phase)
        PH_DATA: begin
          if (wr_op && wel && in_range) mem_we = 1'b1;
          if (rd_op) rsel = (is_flash && !in_range) ? RS_FF : RS_MEM;
          else if (is_flash && cmd == OP_WRITE_HI && in_range) rsel = RS_MEM;
        end
        PH_HOLD: if (cmd == OP_RDSR) rsel = RS_STATUS;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_CMD;
      cmd   <= '0;
      acnt  <= '0;
      addr  <= '0;
      wel   <= 1'b0;
      wrote <= 1'b0;
    end else if (cs_n) begin
      phase <= PH_CMD;
      cmd   <= '0;
      acnt  <= '0;
      addr  <= '0;
      if (wrote) begin
        wel   <= 1'b0;
        wrote <= 1'b0;
      end
    end else if (byte_stb) begin
      case (phase)
        PH_CMD: begin
          cmd <= byte_in;
          if (byte_in == OP_WREN) wel <= 1'b1;
          if (byte_in == OP_WRDI) wel <= 1'b0;
          if (is_rw_op(byte_in)) begin
            phase <= PH_ADDR;
            acnt  <= ACNT_INIT;
            addr  <= (TINY && !is_flash && byte_in[3]) ? AREG_W'(1) : '0;
          end else begin
            phase <= PH_HOLD;
          end
        end
        PH_ADDR: begin
          addr <= {addr[AREG_W-9:0], byte_in};
          if (acnt == 2'd0) phase <= PH_DATA;
          else              acnt  <= acnt - 2'd1;
        end
        PH_DATA: begin
          addr <= addr + AREG_W'(1);
          if (mem_we) wrote <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R2
  wel_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> $past(!cs_n && byte_stb && phase == PH_CMD && byte_in == OP_WREN));

  // R10
  wel_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wel) |-> $past(cs_n || (byte_stb && phase == PH_CMD && byte_in == OP_WRDI)));

  // R11
  cs_restart_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (phase == PH_CMD && addr == '0));

  // R9
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (stb_act && phase == PH_DATA) |=> (addr == $past(addr) + AREG_W'(1)));

endmodule

// File: rtl/spi_save_responder.sv
module spi_save_responder
  import spi_save_pkg::*;
#(
  parameter int MEM_BYTES = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       byte_stb,
  input  logic [7:0] byte_in,
  input  logic       is_flash,
  output logic       resp_valid,
  output logic [7:0] resp_byte
);

  localparam int ADDR_BYTES = addr_bytes_for(MEM_BYTES);
  localparam int MEM_AW     = $clog2(MEM_BYTES);
  localparam int AREG_W     = (ADDR_BYTES * 8 > MEM_AW) ? ADDR_BYTES * 8 + 1 : MEM_AW + 1;

  logic              mem_we, wel, stb_act;
  logic [MEM_AW-1:0] mem_addr;
  logic [7:0]        rdata, stat_q;
  rsel_t             rsel, rsel_q;

  assign stb_act = byte_stb & ~cs_n;

  save_cmd_seq #(
    .MEM_BYTES (MEM_BYTES),
    .ADDR_BYTES(ADDR_BYTES),
    .MEM_AW    (MEM_AW),
    .AREG_W    (AREG_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .byte_stb(byte_stb),
    .byte_in (byte_in),
    .is_flash(is_flash),
    .mem_we  (mem_we),
    .mem_addr(mem_addr),
    .rsel    (rsel),
    .wel     (wel)
  );

  save_mem_array #(
    .DEPTH(MEM_BYTES),
    .AW   (MEM_AW)
  ) u_mem (
    .clk  (clk),
    .rd_en(stb_act),
    .we   (mem_we),
    .addr (mem_addr),
    .wdata(byte_in),
    .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      rsel_q     <= RS_FF;
      stat_q     <= '0;
    end else begin
      resp_valid <= stb_act;
      if (stb_act) begin
        rsel_q <= rsel;
        stat_q <= {6'b0, wel, 1'b0};
      end
    end
  end

  always_comb begin
    case (rsel_q)
      RS_STATUS: resp_byte = stat_q;
      RS_MEM:    resp_byte = rdata;
      default:   resp_byte = IDLE_BYTE;
    endcase
  end

  // R13
  resp_align_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(byte_stb && !cs_n));

  // R1
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> !resp_valid);

endmodule

// File: tb/spi_save_responder_test.sv
module spi_save_responder_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = 8'h00;
  logic       csa = 1'b1, stba = 1'b0, fla = 1'b0;
  logic       csb = 1'b1, stbb = 1'b0, flb = 1'b0;
  logic       rva, rvb;
  logic [7:0] rba, rbb;

  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 1'b0;

  logic [7:0] qexp_a[$], qexp_b[$];
  string      qtag_a[$], qtag_b[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_save_responder #(.MEM_BYTES(512)) uut (
    .clk(clk), .rst(rst), .cs_n(csa), .byte_stb(stba), .byte_in(din),
    .is_flash(fla), .resp_valid(rva), .resp_byte(rba)
  );

  spi_save_responder #(.MEM_BYTES(1024)) uut_wide (
    .clk(clk), .rst(rst), .cs_n(csb), .byte_stb(stbb), .byte_in(din),
    .is_flash(flb), .resp_valid(rvb), .resp_byte(rbb)
  );

  task automatic compare(input bit w, input logic [7:0] got);
    logic [7:0] e;
    string t;
    vectors++;
    if ((w ? qexp_b.size() : qexp_a.size()) == 0) begin
      miscompares++;
      $display("FAIL R13: unexpected response on %s actual %02h expected none",
               w ? "wide" : "narrow", got);
    end else begin
      if (w) begin e = qexp_b.pop_front(); t = qtag_b.pop_front(); end
      else   begin e = qexp_a.pop_front(); t = qtag_a.pop_front(); end
      if (got !== e) begin
        miscompares++;
        $display("FAIL %s: %s response actual %02h expected %02h",
                 t, w ? "wide" : "narrow", got, e);
      end
    end
  endtask

  // monitor: pops expected items as responses appear
  always @(negedge clk) begin
    if (!rst) begin
      if (rva) compare(1'b0, rba);
      if (rvb) compare(1'b1, rbb);
    end
  end

  task automatic sel(input bit w, input logic v);
    @(negedge clk);
    if (w) csb = v; else csa = v;
    @(negedge clk);
  endtask

  task automatic xfer(input bit w, input logic [7:0] b, input logic [7:0] e, input string tag);
    @(negedge clk);
    din = b;
    if (w) begin stbb = 1'b1; qexp_b.push_back(e); qtag_b.push_back(tag); end
    else   begin stba = 1'b1; qexp_a.push_back(e); qtag_a.push_back(tag); end
    @(negedge clk);
    stba = 1'b0;
    stbb = 1'b0;
  endtask

  task automatic wren(input bit w);
    sel(w, 1'b0);
    xfer(w, 8'h06, 8'hFF, "R2");
    sel(w, 1'b1);
  endtask

  // strobe with chip-select high on the narrow instance
  task automatic stray(input logic [7:0] b);
    @(negedge clk);
    din = b;
    stba = 1'b1;
    @(negedge clk);
    stba = 1'b0;
    vectors++;
    if (rva !== 1'b0) begin
      miscompares++;
      $display("FAIL R1: response while deselected actual %0b expected 0", rva);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (rva !== 1'b0 || rvb !== 1'b0) begin
      miscompares++;
      $display("FAIL R13: reset response valid actual %0b%0b expected 00", rva, rvb);
    end
    rst = 1'b0;
    @(negedge clk);

    // R2: status clear after reset, then set by 0x06
    sel(0, 0); xfer(0, 8'h05, 8'hFF, "R1"); xfer(0, 8'h00, 8'h00, "R2"); sel(0, 1);
    wren(0);
    sel(0, 0); xfer(0, 8'h05, 8'hFF, "R1"); xfer(0, 8'h00, 8'h02, "R2"); sel(0, 1);

    // R3 R10: write two bytes at 0x010, latch drops afterwards
    sel(0, 0); xfer(0, 8'h02, 8'hFF, "R1"); xfer(0, 8'h10, 8'hFF, "R3");
    xfer(0, 8'hAA, 8'hFF, "R6"); xfer(0, 8'hBB, 8'hFF, "R6"); sel(0, 1);
    sel(0, 0); xfer(0, 8'h05, 8'hFF, "R1"); xfer(0, 8'h00, 8'h00, "R10"); sel(0, 1);

    // R10: write without latch is dropped
    sel(0, 0); xfer(0, 8'h02, 8'hFF, "R1"); xfer(0, 8'h10, 8'hFF, "R3");
    xfer(0, 8'hCC, 8'hFF, "R10"); sel(0, 1);
    sel(0, 0); xfer(0, 8'h03, 8'hFF, "R1"); xfer(0, 8'h10, 8'hFF, "R3");
    xfer(0, 8'h00, 8'hAA, "R10"); xfer(0, 8'h00, 8'hBB, "R9"); xfer(0, 8'h00, 8'hFF, "R12");
    sel(0, 1);

    // R4: opcode bit 3 selects the upper half
    wren(0);
    sel(0, 0); xfer(0, 8'h0A, 8'hFF, "R1"); xfer(0, 8'h05, 8'hFF, "R3");
    xfer(0, 8'h5A, 8'hFF, "R6"); sel(0, 1);
    sel(0, 0); xfer(0, 8'h0B, 8'hFF, "R1"); xfer(0, 8'h05, 8'hFF, "R3");
    xfer(0, 8'h00, 8'h5A, "R4"); sel(0, 1);
    sel(0, 0); xfer(0, 8'h03, 8'hFF, "R1"); xfer(0, 8'h05, 8'hFF, "R3");
    xfer(0, 8'h00, 8'hFF, "R4"); sel(0, 1);

    // R5 R6: wrap on read, write past end ignored
    wren(0);
    sel(0, 0); xfer(0, 8'h02, 8'hFF, "R1"); xfer(0, 8'h00, 8'hFF, "R3");
    xfer(0, 8'h11, 8'hFF, "R6"); sel(0, 1);
    wren(0);
    sel(0, 0); xfer(0, 8'h0A, 8'hFF, "R1"); xfer(0, 8'hFF, 8'hFF, "R3");
    xfer(0, 8'h77, 8'hFF, "R6"); xfer(0, 8'h88, 8'hFF, "R6"); sel(0, 1);
    sel(0, 0); xfer(0, 8'h0B, 8'hFF, "R1"); xfer(0, 8'hFF, 8'hFF, "R3");
    xfer(0, 8'h00, 8'h77, "R4"); xfer(0, 8'h00, 8'h11, "R5"); sel(0, 1);

    // R1 R11: deselected strobe ignored, select rise aborts a command
    stray(8'h06);
    sel(0, 0); xfer(0, 8'h03, 8'hFF, "R11"); sel(0, 1);
    sel(0, 0); xfer(0, 8'h05, 8'hFF, "R11"); xfer(0, 8'h00, 8'h00, "R11"); sel(0, 1);

    // wide store, EEPROM: two address bytes, beyond-end write dropped
    wren(1);
    sel(1, 0); xfer(1, 8'h02, 8'hFF, "R1"); xfer(1, 8'h00, 8'hFF, "R3");
    xfer(1, 8'h00, 8'hFF, "R3"); xfer(1, 8'h21, 8'hFF, "R6"); sel(1, 1);
    wren(1);
    sel(1, 0); xfer(1, 8'h02, 8'hFF, "R1"); xfer(1, 8'h04, 8'hFF, "R3");
    xfer(1, 8'h00, 8'hFF, "R3"); xfer(1, 8'h99, 8'hFF, "R6"); sel(1, 1);
    sel(1, 0); xfer(1, 8'h03, 8'hFF, "R1"); xfer(1, 8'h04, 8'hFF, "R3");
    xfer(1, 8'h00, 8'hFF, "R3"); xfer(1, 8'h00, 8'h21, "R5"); sel(1, 1);

    // wide store, flash
    flb = 1'b1;
    wren(1);
    sel(1, 0); xfer(1, 8'h02, 8'hFF, "R1"); xfer(1, 8'h03, 8'hFF, "R3");
    xfer(1, 8'hFF, 8'hFF, "R3"); xfer(1, 8'h44, 8'hFF, "R8"); sel(1, 1);
    sel(1, 0); xfer(1, 8'h03, 8'hFF, "R1"); xfer(1, 8'h03, 8'hFF, "R3");
    xfer(1, 8'hFF, 8'hFF, "R3"); xfer(1, 8'h00, 8'h44, "R8"); xfer(1, 8'h00, 8'hFF, "R7");
    sel(1, 1);
    wren(1);
    sel(1, 0); xfer(1, 8'h0A, 8'hFF, "R1"); xfer(1, 8'h00, 8'hFF, "R3");
    xfer(1, 8'h00, 8'hFF, "R3"); xfer(1, 8'h55, 8'h21, "R8"); sel(1, 1);
    sel(1, 0); xfer(1, 8'h0A, 8'hFF, "R1"); xfer(1, 8'h00, 8'hFF, "R3");
    xfer(1, 8'h00, 8'hFF, "R3"); xfer(1, 8'h66, 8'h55, "R10"); sel(1, 1);
    sel(1, 0); xfer(1, 8'h03, 8'hFF, "R1"); xfer(1, 8'h00, 8'hFF, "R3");
    xfer(1, 8'h00, 8'hFF, "R3"); xfer(1, 8'h00, 8'h55, "R10"); sel(1, 1);

    repeat (4) @(negedge clk);
    vectors++;
    if (qexp_a.size() != 0 || qexp_b.size() != 0) begin
      miscompares++;
      $display("FAIL R13: missing responses actual %0d expected 0",
               qexp_a.size() + qexp_b.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule